// File: doc/BRIEF.md
# Multi-Speed Serial Clock Rate Generator

This block produces the serial clock for a two-wire bus master from the system clock. It supports three bus speeds: standard, fast and high speed. Each speed has its own pair of count registers. One register sets how many system cycles the clock stays high, and the other sets how many cycles it stays low. A two-bit speed field in a control register selects which pair is used. The count register address for a speed is a fixed base plus the speed index shifted left by three, so one address rule covers all three pairs.

Software programs the registers through a simple write port while `enable` is low. Setting `enable` high starts the clock. The block then counts system cycles through alternating high and low phases. It also produces a one-cycle tick on each falling and each rising edge of the clock, which the byte engine uses to place data and sample it. While `enable` is low, the clock output rests high and the phase counter is held at zero.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl` is 1 and `tick_rise` and `tick_fall` are 0.
- R2: While `enable` is 0, `scl` is 1, no tick is produced and the phase counter is cleared. A later enable therefore starts with a full high phase, counted from the first clock edge that samples `enable` as 1.
- R3: Control register bits [2:1] select the speed: 1 is standard, 2 is fast, 3 is high speed, and 0 is treated as standard.
- R4: The control register is at address 0x00. The high and low count registers are at 0x14 and 0x18 for standard, 0x1C and 0x20 for fast, and 0x24 and 0x28 for high speed. Each is the standard address plus the speed index (0, 1 or 2) shifted left by three.
- R5: Each high phase lasts exactly the selected high count in system cycles.
- R6: Each low phase lasts exactly the selected low count in system cycles.
- R7: A count of 0 is treated as 1.
- R8: Register writes made while `enable` is 1 are ignored. This covers the control register as well as the count registers.
- R9: `tick_fall` is high for one cycle in the cycle where `scl` has just gone from 1 to 0. `tick_rise` is high for one cycle in the cycle where `scl` has just gone from 0 to 1. The two ticks are never high together.
- R10: The reset values select standard speed, with counts 0x75/0x7C for standard, 0x15/0x21 for fast and 0x07/0x0E for high speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 16 | Register write data |
| enable | input | 1 | Runs the clock; also locks the registers |
| scl | output | 1 | Generated serial clock |
| tick_rise | output | 1 | One-cycle pulse with each rising edge of `scl` |
| tick_fall | output | 1 | One-cycle pulse with each falling edge of `scl` |

## Verification
The bench measures every phase, from the first enabled edge onward, and compares it against the programmed counts. A counter with an off-by-one error would make every phase one cycle too long or too short, and the first phase after enable would not match either. Speed field 0 and counts of zero are tested directly: wrong decoding would pick the wrong pair of registers, and a missing clamp would make the counter wrap and stretch the phase to the full counter range. Writes made while enabled, and a disable in the middle of a phase, are both followed by fresh runs. A design that accepted locked writes would show the new counts, and one that kept a stale counter would produce a shortened first high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int NUM_SPEEDS = 3;
    localparam int ADDR_W     = 8;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HS   = 2'd2
    } speed_idx_e;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_HI_BASE = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_LO_BASE = 8'h18;

    // Field value 0 falls back to standard speed.
    function automatic speed_idx_e decode_speed(input logic [1:0] field);
        case (field)
            2'd2:    return SPD_FAST;
            2'd3:    return SPD_HS;
            default: return SPD_STD;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] hi_ofs(input int idx);
        return OFS_HI_BASE + ADDR_W'(idx << 3);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_ofs(input int idx);
        return OFS_LO_BASE + ADDR_W'(idx << 3);
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter logic [CNT_W-1:0] RST_HI_STD  = 'h75,
    parameter logic [CNT_W-1:0] RST_LO_STD  = 'h7C,
    parameter logic [CNT_W-1:0] RST_HI_FAST = 'h15,
    parameter logic [CNT_W-1:0] RST_LO_FAST = 'h21,
    parameter logic [CNT_W-1:0] RST_HI_HS   = 'h07,
    parameter logic [CNT_W-1:0] RST_LO_HS   = 'h0E
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              lock,
    output speed_idx_e                        speed,
    output logic [NUM_SPEEDS-1:0][CNT_W-1:0]  hi_cnt,
    output logic [NUM_SPEEDS-1:0][CNT_W-1:0]  lo_cnt
);

    localparam logic [CNT_W-1:0] RST_HI [NUM_SPEEDS] = '{RST_HI_STD, RST_HI_FAST, RST_HI_HS};
    localparam logic [CNT_W-1:0] RST_LO [NUM_SPEEDS] = '{RST_LO_STD, RST_LO_FAST, RST_LO_HS};

    logic       wr_ok;
    logic [1:0] spd_field_q;

    assign wr_ok = wr_en && !lock;

    always_ff @(posedge clk) begin
        if (rst)
            spd_field_q <= 2'd1;
        else if (wr_ok && wr_addr == OFS_CTRL)
            spd_field_q <= wr_data[2:1];
    end

    assign speed = decode_speed(spd_field_q);

    for (genvar g = 0; g < NUM_SPEEDS; g++) begin : g_pair
        logic [CNT_W-1:0] hi_q;
        logic [CNT_W-1:0] lo_q;

        always_ff @(posedge clk) begin
            if (rst)
                hi_q <= RST_HI[g];
            else if (wr_ok && wr_addr == hi_ofs(g))
                hi_q <= wr_data[CNT_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst)
                lo_q <= RST_LO[g];
            else if (wr_ok && wr_addr == lo_ofs(g))
                lo_q <= wr_data[CNT_W-1:0];
        end

        assign hi_cnt[g] = hi_q;
        assign lo_cnt[g] = lo_q;
    end

endmodule

// File: rtl/scl_count_sel.sv
module scl_count_sel
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  speed_idx_e                        speed,
    input  logic [NUM_SPEEDS-1:0][CNT_W-1:0]  hi_cnt,
    input  logic [NUM_SPEEDS-1:0][CNT_W-1:0]  lo_cnt,
    output logic [CNT_W-1:0]                  hi_len,
    output logic [CNT_W-1:0]                  lo_len
);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    always_comb begin
        hi_len = at_least_one(hi_cnt[speed]);
        lo_len = at_least_one(lo_cnt[speed]);
    end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             scl,
    output logic             tick_rise,
    output logic             tick_fall
);

    logic [CNT_W-1:0] cnt_q;
    logic             scl_q;
    logic             rise_q;
    logic             fall_q;
    logic [CNT_W-1:0] last;

    assign last = (scl_q ? hi_len : lo_len) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q  <= '0;
            scl_q  <= 1'b1;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (cnt_q == last) begin
            cnt_q  <= '0;
            scl_q  <= !scl_q;
            rise_q <= !scl_q;
            fall_q <= scl_q;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end
    end

    assign scl       = scl_q;
    assign tick_rise = rise_q;
    assign tick_fall = fall_q;

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enable,
    output logic              scl,
    output logic              tick_rise,
    output logic              tick_fall
);

    speed_idx_e                       speed;
    logic [NUM_SPEEDS-1:0][CNT_W-1:0] hi_cnt;
    logic [NUM_SPEEDS-1:0][CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0]                 cur_hi;
    logic [CNT_W-1:0]                 cur_lo;

    scl_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock    (enable),
        .speed   (speed),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt)
    );

    scl_count_sel #(.CNT_W(CNT_W)) sel_i (
        .speed   (speed),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .hi_len  (cur_hi),
        .lo_len  (cur_lo)
    );

    scl_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .hi_len    (cur_hi),
        .lo_len    (cur_lo),
        .scl       (scl),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             scl,
    input logic             tick_rise,
    input logic             tick_fall,
    input logic [CNT_W-1:0] cur_hi,
    input logic [CNT_W-1:0] cur_lo
);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (scl && !tick_rise && !tick_fall));

    assert_ticks_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(tick_rise && tick_fall));

    assert_fall_tick_edge_R9: assert property (@(posedge clk) disable iff (rst)
        tick_fall |-> (!scl && $past(scl)));

    assert_rise_tick_edge_R9: assert property (@(posedge clk) disable iff (rst)
        tick_rise |-> (scl && !$past(scl)));

    assert_locked_counts_R8: assert property (@(posedge clk) disable iff (rst)
        $past(enable) |-> ($stable(cur_hi) && $stable(cur_lo)));

endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .scl       (scl),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .cur_hi    (cur_hi),
    .cur_lo    (cur_lo)
);

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        enable = 1'b0;
    logic        scl;
    logic        tick_rise;
    logic        tick_fall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit    fall;
        int    len;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    scl_rate_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .enable    (enable),
        .scl       (scl),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enable as the design saw it at the last rising edge.
    logic en_s = 1'b0;
    always @(posedge clk) en_s = enable && !rst;

    // Monitor: measure every phase and compare with the scoreboard.
    int run = 0;
    always @(negedge clk) begin
        if (!en_s) begin
            run = 0;
        end else begin
            run++;
            if (tick_rise || tick_fall) begin
                check(!(tick_rise && tick_fall), "R9 both ticks", 1, 0);
                if (exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(tick_fall == e.fall, {e.tag, " tick kind"}, int'(tick_fall), int'(e.fall));
                    check(run == e.len, {e.tag, " phase length"}, run, e.len);
                end
                run = 0;
            end
        end
    end

    task automatic drive_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        drive_edge();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        drive_edge();
        wr_en = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        check(scl == 1'b1, {tag, " scl idle high"}, int'(scl), 1);
        check(!tick_rise && !tick_fall, {tag, " no tick idle"}, int'(tick_rise | tick_fall), 0);
    endtask

    task automatic run_phases(input int h, input int l, input int pairs, input string tag);
        for (int i = 0; i < pairs; i++) begin
            exp_q.push_back('{fall: 1'b1, len: h, tag: {tag, " high"}});
            exp_q.push_back('{fall: 1'b0, len: l, tag: {tag, " low"}});
        end
        drive_edge();
        enable = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        drive_edge();
        enable = 1'b0;
        @(posedge clk);
        check_idle("R2");
    endtask

    task automatic finish_report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", c_dummy(), 0);
            finish_report();
        end
    end

    function automatic int c_dummy();
        return exp_q.size();
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        check(scl == 1'b1, "R1 scl after reset", int'(scl), 1);
        check(!tick_rise && !tick_fall, "R1 ticks after reset", int'(tick_rise | tick_fall), 0);

        // R10: default counts, standard speed
        run_phases('h75, 'h7C, 2, "R10");

        // R4 / R5 / R6: standard pair at 0x14/0x18, speed field 1
        reg_write(8'h14, 16'd5);
        reg_write(8'h18, 16'd7);
        reg_write(8'h00, 16'h0002);
        run_phases(5, 7, 3, "R5 R6 std");

        // R3 / R4: fast pair at 0x1C/0x20, speed field 2
        reg_write(8'h1C, 16'd3);
        reg_write(8'h20, 16'd4);
        reg_write(8'h00, 16'h0004);
        run_phases(3, 4, 3, "R3 fast");

        // R3 / R4: high-speed pair at 0x24/0x28, speed field 3
        reg_write(8'h24, 16'd2);
        reg_write(8'h28, 16'd6);
        reg_write(8'h00, 16'h0006);
        run_phases(2, 6, 3, "R4 hs");

        // R3: speed field 0 acts as standard
        reg_write(8'h00, 16'h0000);
        run_phases(5, 7, 2, "R3 field0");

        // R7: zero counts clamp to one
        reg_write(8'h14, 16'd0);
        reg_write(8'h18, 16'd0);
        run_phases(1, 1, 3, "R7 both zero");
        reg_write(8'h18, 16'd2);
        run_phases(1, 2, 2, "R7 high zero");

        // R8: writes while enabled are ignored
        reg_write(8'h14, 16'd4);
        reg_write(8'h18, 16'd3);
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back('{fall: 1'b1, len: 4, tag: "R8 high"});
            exp_q.push_back('{fall: 1'b0, len: 3, tag: "R8 low"});
        end
        drive_edge();
        enable = 1'b1;
        reg_write(8'h14, 16'd9);
        reg_write(8'h18, 16'd9);
        reg_write(8'h00, 16'h0006);
        while (exp_q.size() != 0) @(negedge clk);
        drive_edge();
        enable = 1'b0;
        @(posedge clk);
        check_idle("R2");
        run_phases(4, 3, 1, "R8 after");

        // R2: disable mid-phase clears the counter
        reg_write(8'h14, 16'd6);
        reg_write(8'h18, 16'd6);
        drive_edge();
        enable = 1'b1;
        repeat (3) drive_edge();
        enable = 1'b0;
        @(posedge clk);
        check_idle("R2 mid");
        check_idle("R2 mid");
        run_phases(6, 6, 2, "R2 restart");

        done = 1;
        finish_report();
    end

endmodule